// File: doc/BRIEF.md
# Two-Wire Bus Control Unit

This block is the control and bus-condition engine of a two-wire (I2C-style) serial interface. Software talks to it through one byte-wide control register on a simple CPU bus. The register holds enables, START and STOP requests, and two status flags. The unit synchronises the SCL and SDA lines and watches them, so it always knows whether another device holds the bus. It creates START and STOP conditions by asserting open-drain drive-low enables.

The unit also owns the transfer-complete flag, the write-collision flag and the interrupt request. It gates address recognition for the slave logic that sits next to it. It merges that slave logic's drive-low requests onto the lines whenever the unit is not acting as master. Data shifting, address comparison and arbitration live in neighbouring blocks. A fixed half-period counter sets the timing of every generated condition.

Top module: `twb_ctrl_unit`

## Requirements
- R1: After reset the control register reads 0x00, neither line is driven low, `irq` is low and `bus_busy` is low.
- R2: Control register bits are: 7 transfer flag, 6 address-recognition enable, 5 START request, 4 STOP request, 3 write-collision flag, 2 interface enable, 1 reserved, 0 interrupt enable. Bits 6, 5, 4, 2 and 0 read back as written. Bit 1 always reads 0.
- R3: `addr_match_en` is high only while both the interface enable and the address-recognition enable are set.
- R4: If the START request is written as 1 while the bus is idle, the unit drives SDA low with SCL released for HALF_PERIOD cycles, then also drives SCL low. At that moment the transfer flag sets. The START request bit stays 1 until software writes it to 0.
- R5: If the START request is written while `bus_busy` is high, SDA is not driven until a STOP has been detected. The START then goes out.
- R6: The transfer flag sets on a `xfer_done` pulse. Writing 1 to bit 7 clears it. Writing 0 to bit 7 leaves it unchanged.
- R7: A `data_we` pulse while the transfer flag is 0 sets the write-collision flag. A `data_we` pulse while the flag is 1 clears it.
- R8: In master mode, writing the STOP request as 1 makes the unit drive SDA low with SCL released for HALF_PERIOD cycles. It then releases both lines, and the STOP bit reads 0 at that point.
- R9: In slave mode, a STOP request drives neither line. It masks the slave drive requests, emits a one-cycle `slv_reset` pulse and clears the STOP bit. At all other times in slave mode, `slv_scl_low` and `slv_sda_low` pass to the drive outputs.
- R10: In the cycle after the interface enable is written as 0, both drive outputs are low, any generated condition is abandoned and `bus_busy` clears.
- R11: `irq` is high exactly while the transfer flag, the interrupt enable and `gie` are all 1.
- R12: `bus_busy` sets when SDA falls while SCL is high. It clears when SDA rises while SCL is high. Both lines are sampled through SYNC_STAGES flip-flops first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| data_we | input | 1 | Data register write strobe (for collision tracking) |
| xfer_done | input | 1 | One-cycle pulse: a byte transfer has completed |
| gie | input | 1 | Global interrupt enable |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| slv_scl_low | input | 1 | Slave logic request to hold SCL low |
| slv_sda_low | input | 1 | Slave logic request to hold SDA low |
| scl_drive_low | output | 1 | Open-drain enable pulling SCL low |
| sda_drive_low | output | 1 | Open-drain enable pulling SDA low |
| slv_reset | output | 1 | Pulse that returns slave logic to the unaddressed state |
| addr_match_en | output | 1 | Address recognition permitted |
| bus_busy | output | 1 | Bus held by some master |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with HALF_PERIOD = 4 and SYNC_STAGES = 2. With these values, the length of each generated START and STOP phase can be counted cycle by cycle against a small exact number. They also keep the synchroniser delay short, so a START requested on a busy bus can be held off for ten cycles and then released by a STOP that the bench drives. The bench models the wired-AND lines itself. This lets the unit see its own START and STOP conditions through the bus monitor.

// File: rtl/twb_pkg.sv
package twb_pkg;

    // Control register layout; bit order is what software decodes.
    typedef struct packed {
        logic flag;   // 7 transfer complete
        logic ack;    // 6 address recognition enable
        logic sta;    // 5 START request
        logic sto;    // 4 STOP request
        logic wcol;   // 3 write collision
        logic en;     // 2 interface enable
        logic rsv;    // 1 reserved, reads 0
        logic ie;     // 0 interrupt enable
    } ctl_t;

    typedef enum logic [1:0] {
        GEN_IDLE,
        GEN_START,
        GEN_HOLD,
        GEN_STOP
    } gen_state_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } drive_t;

    function automatic drive_t gen_drive(gen_state_e s);
        drive_t d;
        case (s)
            GEN_START: d = '{scl_low: 1'b0, sda_low: 1'b1};
            GEN_HOLD:  d = '{scl_low: 1'b1, sda_low: 1'b1};
            GEN_STOP:  d = '{scl_low: 1'b0, sda_low: 1'b1};
            default:   d = '{scl_low: 1'b0, sda_low: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/twb_bus_monitor.sv
module twb_bus_monitor
    import twb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_det,
    output logic stop_det,
    output logic busy
);
    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) begin
                scl_sh[i] <= 1'b1;
                sda_sh[i] <= 1'b1;
            end else if (i == 0) begin
                scl_sh[i] <= scl_in;
                sda_sh[i] <= sda_in;
            end else begin
                scl_sh[i] <= scl_sh[(i == 0) ? 0 : i-1];
                sda_sh[i] <= sda_sh[(i == 0) ? 0 : i-1];
            end
        end
    end

    logic scl_s, sda_s, scl_p, sda_p;
    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign start_det = en & scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = en & scl_s & scl_p & ~sda_p & sda_s;

    always_ff @(posedge clk) begin
        if (rst || !en)     busy <= 1'b0;
        else if (start_det) busy <= 1'b1;
        else if (stop_det)  busy <= 1'b0;
    end

    a_r12_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        start_det |=> busy);
    a_r12_stop_clears_busy: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !busy);

endmodule

// File: rtl/twb_cond_gen.sv
module twb_cond_gen
    import twb_pkg::*;
#(
    parameter int HALF_PERIOD = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   sta_write,
    input  logic   sto_bit,
    input  logic   busy,
    output drive_t drv,
    output logic   master,
    output logic   start_sent,
    output logic   sto_clear,
    output logic   slv_reset
);
    localparam int CW = $clog2(HALF_PERIOD + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

    gen_state_e     state;
    logic [CW-1:0]  cnt;
    logic           pending;
    logic           take;
    logic           last;

    assign last       = (cnt == LAST);
    assign take       = en && state == GEN_IDLE && pending && !busy;
    assign start_sent = en && state == GEN_START && last;
    assign slv_reset  = en && state == GEN_IDLE && sto_bit;
    assign sto_clear  = slv_reset || (en && state == GEN_STOP && last);
    assign master     = state != GEN_IDLE;
    assign drv        = gen_drive(state);

    always_ff @(posedge clk) begin
        if (rst)                 pending <= 1'b0;
        else if (sta_write)      pending <= 1'b1;
        else if (!en || take)    pending <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state <= GEN_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                GEN_IDLE: begin
                    cnt <= '0;
                    if (take) state <= GEN_START;
                end
                GEN_START: begin
                    cnt <= cnt + 1'b1;
                    if (last) begin
                        state <= GEN_HOLD;
                        cnt   <= '0;
                    end
                end
                GEN_HOLD: begin
                    cnt <= '0;
                    if (sto_bit) state <= GEN_STOP;
                end
                GEN_STOP: begin
                    cnt <= cnt + 1'b1;
                    if (last) begin
                        state <= GEN_IDLE;
                        cnt   <= '0;
                    end
                end
                default: state <= GEN_IDLE;
            endcase
        end
    end

    a_r5_no_start_on_busy: assert property (@(posedge clk) disable iff (rst)
        (state == GEN_IDLE && busy) |=> state != GEN_START);
    a_r10_off_goes_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> state == GEN_IDLE);
    a_r4_start_then_hold: assert property (@(posedge clk) disable iff (rst)
        start_sent |=> state == GEN_HOLD);
    a_r8_stop_ends_idle: assert property (@(posedge clk) disable iff (rst)
        (en && state == GEN_STOP && last) |=> state == GEN_IDLE);

endmodule

// File: rtl/twb_ctl_reg.sv
module twb_ctl_reg
    import twb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       data_we,
    input  logic       xfer_done,
    input  logic       start_sent,
    input  logic       sto_clear,
    output ctl_t       q
);
    ctl_t w;
    assign w = ctl_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (we) begin
                q.ack <= w.ack;
                q.sta <= w.sta;
                q.sto <= w.sto;
                q.en  <= w.en;
                q.ie  <= w.ie;
                if (w.flag) q.flag <= 1'b0;
            end else if (sto_clear) begin
                q.sto <= 1'b0;
            end
            if (xfer_done || start_sent) q.flag <= 1'b1;
            if (data_we) q.wcol <= ~q.flag;
            q.rsv <= 1'b0;
        end
    end

    a_r7_wcol_sets: assert property (@(posedge clk) disable iff (rst)
        (data_we && !q.flag) |=> q.wcol);
    a_r7_wcol_clears: assert property (@(posedge clk) disable iff (rst)
        (data_we && q.flag) |=> !q.wcol);
    a_r6_flag_sets: assert property (@(posedge clk) disable iff (rst)
        (xfer_done || start_sent) |=> q.flag);
    a_r8_sto_self_clear: assert property (@(posedge clk) disable iff (rst)
        (sto_clear && !we) |=> !q.sto);

endmodule

// File: rtl/twb_ctrl_unit.sv
module twb_ctrl_unit
    import twb_pkg::*;
#(
    parameter int HALF_PERIOD = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic       data_we,
    input  logic       xfer_done,
    input  logic       gie,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       slv_scl_low,
    input  logic       slv_sda_low,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    output logic       slv_reset,
    output logic       addr_match_en,
    output logic       bus_busy,
    output logic       irq
);
    ctl_t   ctl;
    drive_t gdrv;
    logic   master, start_sent, sto_clear;
    logic   start_det, stop_det;
    logic   slv_pass;

    twb_ctl_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .we         (ctl_we),
        .wdata      (ctl_wdata),
        .data_we    (data_we),
        .xfer_done  (xfer_done),
        .start_sent (start_sent),
        .sto_clear  (sto_clear),
        .q          (ctl)
    );

    twb_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk       (clk),
        .rst       (rst),
        .en        (ctl.en),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .start_det (start_det),
        .stop_det  (stop_det),
        .busy      (bus_busy)
    );

    twb_cond_gen #(.HALF_PERIOD(HALF_PERIOD)) u_gen (
        .clk        (clk),
        .rst        (rst),
        .en         (ctl.en),
        .sta_write  (ctl_we && ctl_wdata[5]),
        .sto_bit    (ctl.sto),
        .busy       (bus_busy),
        .drv        (gdrv),
        .master     (master),
        .start_sent (start_sent),
        .sto_clear  (sto_clear),
        .slv_reset  (slv_reset)
    );

    assign slv_pass      = ctl.en && !master && !ctl.sto;
    assign scl_drive_low = ctl.en && (gdrv.scl_low || (slv_pass && slv_scl_low));
    assign sda_drive_low = ctl.en && (gdrv.sda_low || (slv_pass && slv_sda_low));
    assign ctl_rdata     = ctl;
    assign addr_match_en = ctl.en && ctl.ack;
    assign irq           = ctl.flag && ctl.ie && gie;

    a_r9_slave_stop_releases: assert property (@(posedge clk) disable iff (rst)
        slv_reset |-> (!scl_drive_low && !sda_drive_low));
    a_r10_off_no_drive: assert property (@(posedge clk) disable iff (rst)
        !ctl.en |-> (!scl_drive_low && !sda_drive_low && !slv_reset));
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> !ctl_rdata[1]);

endmodule

// File: tb/twb_ctrl_unit_tb.sv
module twb_ctrl_unit_tb;
    localparam int HP = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       data_we = 1'b0, xfer_done = 1'b0, gie = 1'b1;
    logic       slv_scl_low = 1'b0, slv_sda_low = 1'b0;
    logic       ext_scl_low = 1'b0, ext_sda_low = 1'b0;
    logic       scl_drive_low, sda_drive_low, slv_reset, addr_match_en, bus_busy, irq;
    logic       scl_in, sda_in;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign scl_in = !(scl_drive_low || ext_scl_low);
    assign sda_in = !(sda_drive_low || ext_sda_low);

    twb_ctrl_unit #(.HALF_PERIOD(HP), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .data_we(data_we), .xfer_done(xfer_done),
        .gie(gie), .scl_in(scl_in), .sda_in(sda_in),
        .slv_scl_low(slv_scl_low), .slv_sda_low(slv_sda_low),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .slv_reset(slv_reset), .addr_match_en(addr_match_en),
        .bus_busy(bus_busy), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic pulse_data();
        @(negedge clk); data_we = 1'b1;
        @(negedge clk); data_we = 1'b0;
    endtask

    // Counts cycles with SDA pulled and SCL released until SCL is pulled.
    task automatic run_start(input string req, output int phase);
        phase = 0;
        for (int i = 0; i < 60 && !scl_drive_low; i++) begin
            if (sda_drive_low) phase++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check(ctl_rdata == 8'h00, "R1 reg", ctl_rdata, 0);
        check(!scl_drive_low && !sda_drive_low, "R1 drive",
              {scl_drive_low, sda_drive_low}, 0);
        check(!irq && !bus_busy, "R1 irq/busy", {irq, bus_busy}, 0);
    endtask

    task automatic t_layout();
        wr(8'h02);
        check(ctl_rdata == 8'h00, "R2 reserved", ctl_rdata, 8'h00);
        wr(8'h47);
        check(ctl_rdata == 8'h45, "R2 readback", ctl_rdata, 8'h45);
        check(addr_match_en, "R3 gate on", addr_match_en, 1);
        wr(8'h05);
        check(!addr_match_en, "R3 ack off", addr_match_en, 0);
        wr(8'h40);
        check(!addr_match_en, "R3 en off", addr_match_en, 0);
        wr(8'h45);
    endtask

    task automatic t_start_idle();
        int ph;
        wr(8'h65);
        run_start("R4", ph);
        check(ph == HP, "R4 start phase", ph, HP);
        check(scl_drive_low && sda_drive_low, "R4 hold", {scl_drive_low, sda_drive_low}, 3);
        check(ctl_rdata[7] && ctl_rdata[5], "R4 flag+sta", ctl_rdata, 8'hA0);
        cyc(2);
        check(bus_busy, "R12 busy on own start", bus_busy, 1);
    endtask

    task automatic t_flag_irq();
        check(irq, "R11 irq", irq, 1);
        gie = 1'b0; cyc(1);
        check(!irq, "R11 gie gate", irq, 0);
        gie = 1'b1;
        wr(8'h45);
        check(ctl_rdata[7], "R6 write0 keeps", ctl_rdata[7], 1);
        wr(8'hC5);
        check(!ctl_rdata[7] && !irq, "R6 w1c", ctl_rdata, 8'h45);
        pulse_done();
        check(ctl_rdata[7] && irq, "R6 done sets", ctl_rdata, 8'hC5);
        wr(8'h44);
        check(!irq, "R11 ie gate", irq, 0);
        wr(8'h45);
    endtask

    task automatic t_wcol();
        pulse_data();
        check(!ctl_rdata[3], "R7 no wcol", ctl_rdata[3], 0);
        wr(8'hC5);
        pulse_data();
        check(ctl_rdata[3], "R7 wcol set", ctl_rdata[3], 1);
        pulse_done();
        pulse_data();
        check(!ctl_rdata[3], "R7 wcol clear", ctl_rdata[3], 0);
    endtask

    task automatic t_stop_master();
        int ph = 0;
        wr(8'h55);
        for (int i = 0; i < 60; i++) begin
            if (sda_drive_low && !scl_drive_low) ph++;
            if (!sda_drive_low && ph > 0) break;
            @(negedge clk);
        end
        check(ph == HP, "R8 stop phase", ph, HP);
        check(!scl_drive_low && !sda_drive_low, "R8 released",
              {scl_drive_low, sda_drive_low}, 0);
        check(!ctl_rdata[4], "R8 sto cleared", ctl_rdata[4], 0);
        cyc(4);
        check(!bus_busy, "R12 busy clear after stop", bus_busy, 0);
    endtask

    task automatic t_start_busy();
        bit early = 1'b0;
        int ph;
        ext_sda_low = 1'b1;
        cyc(6);
        check(bus_busy, "R12 ext start", bus_busy, 1);
        wr(8'h65);
        for (int i = 0; i < 10; i++) begin
            if (sda_drive_low) early = 1'b1;
            @(negedge clk);
        end
        check(!early, "R5 held off", early, 0);
        ext_sda_low = 1'b0;
        run_start("R5", ph);
        check(ph == HP && scl_drive_low, "R5 start after stop", ph, HP);
        wr(8'hD5);
        cyc(2 * HP + 6);
        check(!bus_busy && !sda_drive_low, "R12 free again", bus_busy, 0);
    endtask

    task automatic t_slave_stop();
        slv_scl_low = 1'b1; cyc(1);
        check(scl_drive_low, "R9 slave pass", scl_drive_low, 1);
        wr(8'h55);
        check(slv_reset && !scl_drive_low && !sda_drive_low, "R9 reset pulse",
              {slv_reset, scl_drive_low, sda_drive_low}, 4);
        cyc(1);
        check(!slv_reset && !ctl_rdata[4], "R9 sto cleared", {slv_reset, ctl_rdata[4]}, 0);
        check(scl_drive_low, "R9 slave pass after", scl_drive_low, 1);
        slv_scl_low = 1'b0;
    endtask

    task automatic t_disable();
        int ph;
        wr(8'h65);
        run_start("R10", ph);
        wr(8'h40);
        check(!scl_drive_low && !sda_drive_low, "R10 drive off",
              {scl_drive_low, sda_drive_low}, 0);
        cyc(2);
        check(!bus_busy, "R10 busy clear", bus_busy, 0);
        wr(8'h44);
        cyc(6);
        check(!scl_drive_low && !sda_drive_low, "R10 stays idle",
              {scl_drive_low, sda_drive_low}, 0);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_layout();
        t_start_idle();
        t_flag_irq();
        t_wcol();
        t_stop_master();
        t_start_busy();
        t_slave_stop();
        t_disable();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule